// File: doc/BRIEF.md
# Gain-Ranging Conversion Sequencer

This block controls a floating-point style analog front end. The front end has a coarse flash pre-sampler, a threshold comparator, a programmable-gain amplifier (PGA) with gains of 1, 2, 4, 8 and 16, and an external 12-bit successive-approximation converter. An execute strobe starts one channel. The block waits out a programmable input settling time. It then captures the comparator and the flash code on the same clock edge. A channel below threshold is closed at once, with no conversion.

A channel above threshold goes through three steps. The flash code picks a PGA gain. A fixed amplifier settling interval follows. The converter is then started and run through a start/busy handshake. The result is a 12-bit mantissa plus a 3-bit range code that gives the power-of-two scale multiplier. Between channels the amplifier sits at gain 16, its slowest range, so every switch away from idle recovers within the settling interval.

All intervals are counted in clock cycles. The input settling count comes from an input port, so it can be adjusted. At 100 MHz, the nominal 1.5 µs is 150 cycles. The amplifier settling count is a parameter.

Top module: `fpadc_seq`

## Requirements
- R1: After reset, `seq_busy`, `res_valid` and `adc_start` are 0, and `pga_gain_log2` is 4 (gain 16).
- R2: An execute strobe seen in idle raises `seq_busy` on the next cycle. The comparator and flash code are captured `settle_cyc`+1 cycles after the accepting edge. A gain change caused by that capture appears on `pga_gain_log2` at that same point.
- R3: If `cmp_over` is 0 at the capture point, the block issues no converter start and does not change the gain. It pulses `res_valid` at the capture point with `res_under`=1, `res_mant`=0 and `res_range`=0.
- R4: Over threshold, the flash code sets the gain. Codes 8 to 15 (top bit set, lower bits ignored) give `pga_gain_log2`=0 and range 4. Codes 4 to 7 give gain code 1 and range 3. Codes 2 to 3 give gain code 2 and range 2. Code 1 gives gain code 3 and range 1. Code 0 gives gain code 4 (gain 16) and range 0.
- R5: A converted result carries `res_under`=0 and `res_mant` equal to `adc_data` as sampled when the block first sees `adc_busy` low after it went high.
- R6: `adc_start` is a one-cycle pulse. It is raised `PGA_SETTLE_CYC`+1 cycles after the capture point.
- R7: `res_valid` lasts exactly one cycle. For a conversion it rises on the edge after the one at which `adc_busy` falls.
- R8: When a channel ends, `seq_busy` falls and `pga_gain_log2` returns to 4 on the same edge that raises `res_valid`. In idle the gain code is always 4.
- R9: An execute strobe that arrives while `seq_busy` is 1 is ignored. It causes no extra converter start, no extra result, and no busy period after the current channel ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_strobe | input | 1 | Starts a channel when idle |
| settle_cyc | input | CNT_W | Input settling interval in cycles |
| cmp_over | input | 1 | Threshold comparator, 1 = over threshold |
| flash_code | input | FLASH_W | Coarse flash pre-sample |
| adc_start | output | 1 | One-cycle converter start |
| adc_busy | input | 1 | Converter busy |
| adc_data | input | MANT_W | Converter result |
| pga_gain_log2 | output | RNG_W | Amplifier gain as log2 (4 = gain 16) |
| seq_busy | output | 1 | Channel in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_under | output | 1 | Result is under threshold (with res_valid) |
| res_mant | output | MANT_W | Mantissa (with res_valid) |
| res_range | output | RNG_W | Range code, scale multiplier = 2^code (with res_valid) |

## Verification
Most faults in this sequencer show up as timing errors at the ports. Two examples are a timer that loads or expires one count off, and a state that skips its wait. Either one moves the gain switch, the converter start or the result strobe by a whole number of cycles within the same channel. For that reason the bench measures these three events to the exact cycle, and does not only wait for them.

A wrong range decode shows up on the gain code as soon as the capture point is reached. The bench sweeps all sixteen flash codes and checks the gain code and the range code against a mapping it computes itself. A state machine that fails to return to idle shows up on the next channel: the amplifier is not parked at gain 16, busy does not fall, or a late strobe produces an extra start.

// File: rtl/fpadc_pkg.sv
package fpadc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_PGA,
        ST_WAIT_HI,
        ST_WAIT_LO
    } seq_state_e;
endpackage

// File: rtl/fpadc_range_sel.sv
module fpadc_range_sel #(
    parameter int unsigned FLASH_W = 4,
    localparam int unsigned RNG_W  = $clog2(FLASH_W + 1)
) (
    input  logic [FLASH_W-1:0] flash_code,
    output logic [RNG_W-1:0]   range_code,
    output logic [RNG_W-1:0]   gain_log2
);
    // Range is one more than the index of the highest set flash bit;
    // the gain exponent is its complement against the top range.
    always_comb begin
        range_code = '0;
        for (int i = 0; i < FLASH_W; i++) begin
            if (flash_code[i]) begin
                range_code = RNG_W'(i + 1);
            end
        end
        gain_log2 = RNG_W'(FLASH_W) - range_code;
    end
endmodule

// File: rtl/fpadc_interval_timer.sv
module fpadc_interval_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R2
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_val != '0)) |=> !zero);
endmodule

// File: rtl/fpadc_seq.sv
module fpadc_seq
    import fpadc_pkg::*;
#(
    parameter int unsigned MANT_W         = 12,
    parameter int unsigned FLASH_W        = 4,
    parameter int unsigned CNT_W          = 8,
    parameter int unsigned PGA_SETTLE_CYC = 150,
    localparam int unsigned RNG_W         = $clog2(FLASH_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec_strobe,
    input  logic [CNT_W-1:0]   settle_cyc,
    input  logic               cmp_over,
    input  logic [FLASH_W-1:0] flash_code,
    output logic               adc_start,
    input  logic               adc_busy,
    input  logic [MANT_W-1:0]  adc_data,
    output logic [RNG_W-1:0]   pga_gain_log2,
    output logic               seq_busy,
    output logic               res_valid,
    output logic               res_under,
    output logic [MANT_W-1:0]  res_mant,
    output logic [RNG_W-1:0]   res_range
);
    localparam logic [RNG_W-1:0] GAIN_IDLE = RNG_W'(FLASH_W);
    localparam logic [CNT_W-1:0] PGA_CNT   = CNT_W'(PGA_SETTLE_CYC);

    typedef struct packed {
        seq_state_e        st;
        logic [RNG_W-1:0]  gain;
        logic              start;
        logic              valid;
        logic              under;
        logic [MANT_W-1:0] mant;
        logic [RNG_W-1:0]  rng;
    } seq_regs_t;

    seq_regs_t         r_d, r_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic [RNG_W-1:0]  sel_rng, sel_gain;

    fpadc_range_sel #(.FLASH_W(FLASH_W)) u_range_sel (
        .flash_code (flash_code),
        .range_code (sel_rng),
        .gain_log2  (sel_gain)
    );

    fpadc_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.valid = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (exec_strobe) begin
                    r_d.st   = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = settle_cyc;
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    if (cmp_over) begin
                        r_d.st   = ST_PGA;
                        r_d.gain = sel_gain;
                        r_d.rng  = sel_rng;
                        tmr_load = 1'b1;
                        tmr_val  = PGA_CNT;
                    end else begin
                        r_d.st    = ST_IDLE;
                        r_d.valid = 1'b1;
                        r_d.under = 1'b1;
                        r_d.mant  = '0;
                        r_d.rng   = '0;
                        r_d.gain  = GAIN_IDLE;
                    end
                end
            end
            ST_PGA: begin
                if (tmr_zero) begin
                    r_d.st    = ST_WAIT_HI;
                    r_d.start = 1'b1;
                end
            end
            ST_WAIT_HI: begin
                if (adc_busy) r_d.st = ST_WAIT_LO;
            end
            ST_WAIT_LO: begin
                if (!adc_busy) begin
                    r_d.st    = ST_IDLE;
                    r_d.valid = 1'b1;
                    r_d.under = 1'b0;
                    r_d.mant  = adc_data;
                    r_d.gain  = GAIN_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, gain: GAIN_IDLE, start: 1'b0, valid: 1'b0,
                     under: 1'b0, mant: '0, rng: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign adc_start     = r_q.start;
    assign pga_gain_log2 = r_q.gain;
    assign seq_busy      = (r_q.st != ST_IDLE);
    assign res_valid     = r_q.valid;
    assign res_under     = r_q.under;
    assign res_mant      = r_q.mant;
    assign res_range     = r_q.rng;

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R9
    start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> seq_busy);

    // R8
    idle_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |-> (pga_gain_log2 == GAIN_IDLE));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R3
    under_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_under) |-> ((res_mant == '0) && (res_range == '0)));
endmodule

// File: tb/fpadc_seq_tb.sv
module fpadc_seq_tb;
    localparam int P    = 20;
    localparam int CONV = 12;
    localparam int LIM  = 3000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exec_strobe;
    logic [7:0]  settle_cyc;
    logic        cmp_over;
    logic [3:0]  flash_code;
    logic        adc_start;
    logic        adc_busy;
    logic [11:0] adc_data;
    logic [2:0]  pga_gain_log2;
    logic        seq_busy, res_valid, res_under;
    logic [11:0] res_mant;
    logic [2:0]  res_range;

    int n_chk  = 0;
    int n_fail = 0;
    int n_start = 0;
    int conv_left = 0;

    always #5 clk = ~clk;

    fpadc_seq #(.PGA_SETTLE_CYC(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .exec_strobe(exec_strobe), .settle_cyc(settle_cyc),
        .cmp_over(cmp_over), .flash_code(flash_code), .adc_start(adc_start),
        .adc_busy(adc_busy), .adc_data(adc_data), .pga_gain_log2(pga_gain_log2),
        .seq_busy(seq_busy), .res_valid(res_valid), .res_under(res_under),
        .res_mant(res_mant), .res_range(res_range)
    );

    // converter model: busy from the edge after start for CONV cycles
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_busy  <= 1'b0;
            conv_left <= 0;
        end else if (adc_start) begin
            adc_busy  <= 1'b1;
            conv_left <= CONV;
            n_start   <= n_start + 1;
        end else if (adc_busy) begin
            if (conv_left == 1) adc_busy <= 1'b0;
            conv_left <= conv_left - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic channel(input int s, input bit over, input logic [3:0] fl,
                           input logic [11:0] m, input bit mid);
        int er, eg, n, n_gain, n_st, n_val, st0;
        er = (fl == 0) ? 0 : (fl >= 8) ? 4 : (fl >= 4) ? 3 : (fl >= 2) ? 2 : 1;
        eg = 4 - er;
        @(negedge clk);
        settle_cyc = 8'(s); cmp_over = over; flash_code = fl; adc_data = m;
        exec_strobe = 1'b1; st0 = n_start;
        @(negedge clk);
        exec_strobe = 1'b0;
        chk(seq_busy == 1'b1, "R2", "busy after execute", int'(seq_busy), 1);
        n_gain = -1; n_st = -1; n_val = -1; n = 0;
        while (n_val < 0 && n < LIM) begin
            @(negedge clk);
            n++;
            exec_strobe = (mid && n == 3);
            if (n_gain < 0 && pga_gain_log2 != 3'd4) begin
                n_gain = n;
                chk(pga_gain_log2 == 3'(eg), "R4", "gain code", int'(pga_gain_log2), eg);
            end
            if (n_st < 0 && adc_start) n_st = n;
            if (res_valid) n_val = n;
        end
        exec_strobe = 1'b0;
        if (over) begin
            chk(n_val == s + P + 4 + CONV, "R7", "cycles to result", n_val, s + P + 4 + CONV);
            chk(n_st == s + P + 2, "R6", "cycles to converter start", n_st, s + P + 2);
            if (eg != 4) chk(n_gain == s + 1, "R2", "cycles to gain switch", n_gain, s + 1);
            else         chk(n_gain == -1, "R4", "gain kept at x16 for code 0", n_gain, -1);
            chk(res_under == 1'b0, "R5", "under flag", int'(res_under), 0);
            chk(res_mant == m, "R5", "mantissa", int'(res_mant), int'(m));
            chk(res_range == 3'(er), "R4", "range code", int'(res_range), er);
        end else begin
            chk(n_val == s + 1, "R3", "cycles to skip result", n_val, s + 1);
            chk(res_under == 1'b1, "R3", "under flag", int'(res_under), 1);
            chk(res_mant == 12'd0, "R3", "mantissa", int'(res_mant), 0);
            chk(res_range == 3'd0, "R3", "range code", int'(res_range), 0);
            chk(n_gain == -1, "R3", "gain switched on skipped channel", n_gain, -1);
        end
        chk(seq_busy == 1'b0, "R8", "busy with result", int'(seq_busy), 0);
        chk(pga_gain_log2 == 3'd4, "R8", "gain parked", int'(pga_gain_log2), 4);
        chk(n_start - st0 == (over ? 1 : 0), "R9", "converter starts", n_start - st0, over ? 1 : 0);
        @(negedge clk);
        chk(res_valid == 1'b0, "R7", "valid width", int'(res_valid), 0);
        if (mid) begin
            repeat (5) @(negedge clk);
            chk(seq_busy == 1'b0, "R9", "late execute ignored", int'(seq_busy), 0);
            chk(n_start - st0 == (over ? 1 : 0), "R9", "no extra start", n_start - st0, over ? 1 : 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; exec_strobe = 1'b0; settle_cyc = 8'd150;
        cmp_over = 1'b0; flash_code = 4'd0; adc_data = 12'd0;
        repeat (3) @(negedge clk);
        chk(seq_busy == 1'b0, "R1", "reset busy", int'(seq_busy), 0);
        chk(res_valid == 1'b0, "R1", "reset valid", int'(res_valid), 0);
        chk(adc_start == 1'b0, "R1", "reset start", int'(adc_start), 0);
        chk(pga_gain_log2 == 3'd4, "R1", "reset gain", int'(pga_gain_log2), 4);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 full flash sweep, R5 mantissa pass-through
        for (int f = 0; f < 16; f++) begin
            channel(3, 1'b1, 4'(f), 12'((f * 257 + 5) & 12'hfff), 1'b0);
        end
        // R3 skipped channels, including flash at top code
        channel(1, 1'b0, 4'd15, 12'hABC, 1'b0);
        channel(150, 1'b0, 4'd5, 12'h123, 1'b1);
        // R2 nominal and short settling, R9 strobes during conversion
        channel(150, 1'b1, 4'd5, 12'hFFF, 1'b1);
        channel(1, 1'b1, 4'd1, 12'h000, 1'b0);
        channel(4, 1'b1, 4'd0, 12'h800, 1'b1);
        channel(250, 1'b1, 4'd9, 12'h555, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule